// File: doc/BRIEF.md
# Two-Level Write Ownership Controller

This block keeps coherence for a shared second-level cache that sits behind two local first-level data caches. It holds a MESI state for each local cache on every tracked line, plus one bit per line that records whether some agent beyond the die may also hold that line. Local caches send read misses and writes through a single request channel. The controller answers each request with the state the requesting cache must install.

A write that needs ownership is settled on the die when only the neighbouring local cache shares the line. In that case the neighbour's copy is dropped and the writer becomes Modified in the next cycle. The write goes to the external bus port only when the outside-sharer bit is set. The controller then holds one external invalidate request until the bus grants it. External snoops set the outside-sharer bit and demote or invalidate the local copies. Data storage, replacement and memory access lie outside this block.

Top module: `ownership_ctrl`

## Requirements
- R1: After reset every local state is Invalid (encoding I=0, S=1, E=2, M=3) and every outside-sharer bit is clear. `rspValid` and `extReqValid` are low, and `reqReady` is high.
- R2: A write (`reqOp`=1) whose requester state is Exclusive or Modified is answered one cycle after acceptance with state M and `rspExt`=0. No external request is raised.
- R3: A write whose requester state is Shared or Invalid, on a line whose outside-sharer bit is clear, is resolved on the die. One cycle after acceptance the response gives M with `rspExt`=0, and the other local cache's copy becomes Invalid.
- R4: A write whose requester state is Shared or Invalid, on a line whose outside-sharer bit is set, raises `extReqValid` with `extReqLine` held steady until `extGrant`. One cycle after the grant the response gives M with `rspExt`=1. The requester is then M, the other local copy is Invalid, and the outside-sharer bit is clear.
- R5: A read (`reqOp`=0) whose requester state is not Invalid changes nothing and returns the current state.
- R6: A read miss returns S if the other local cache holds the line or the outside-sharer bit is set; otherwise it returns E. An other copy in M or E is demoted to S.
- R7: A snoop with `snoopKind`=0 (external read) demotes local M/E copies of the line to S. A snoop with `snoopKind`=1 (external invalidate) makes both local copies Invalid. Both kinds set the line's outside-sharer bit.
- R8: `reqReady` is low for a request to the line of the pending external request, or for a request that would itself need the bus while one is pending. It is also low during the grant cycle and while a snoop to the same line is present. Requests to other, locally resolvable lines stay accepted.
- R9: No line is ever held by one local cache in M or E while the other local cache holds it in any non-Invalid state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqCore | input | 1 | Requesting local cache (0 or 1) |
| reqOp | input | 1 | 0 read, 1 write |
| reqLine | input | LINE_W | Tracked line index |
| rspValid | output | 1 | One-cycle response strobe |
| rspCore | output | 1 | Local cache the response belongs to |
| rspState | output | 2 | State to install (I=0, S=1, E=2, M=3) |
| rspExt | output | 1 | Response completed through the external bus |
| snoopValid | input | 1 | External snoop present |
| snoopKind | input | 1 | 0 external read, 1 external invalidate |
| snoopLine | input | LINE_W | Snooped line index |
| extReqValid | output | 1 | External invalidate request pending |
| extReqLine | output | LINE_W | Line of the pending external request |
| extGrant | input | 1 | External bus grants the pending request |

## Verification
The main function is driven with a walk of reads and writes over a few lines. The walk moves each line through E, silent E-to-M upgrade, sharing with the neighbour, and ownership taken from S and from I, so that the silent, fill and local ownership paths are told apart. Writes made after snoops separate the local-only path from the external path. A second write after the grant shows that the outside-sharer bit was cleared. Reads issued after each snoop kind distinguish demotion from invalidation. Holding the bus grant back exposes the per-line stall, and shows that a request to a different line still proceeds.

// File: rtl/own_pkg.sv
package own_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  localparam logic OP_READ  = 1'b0;
  localparam logic OP_WRITE = 1'b1;
  localparam logic SNP_READ = 1'b0;
  localparam logic SNP_INV  = 1'b1;

  // strobes from control to the state tables
  typedef struct packed {
    logic hitRead;
    logic fillRead;
    logic localOwn;
    logic launchExt;
    logic finishExt;
  } strobe_t;
endpackage

// File: rtl/own_datapath.sv
module own_datapath
  import own_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              reqCore,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              snoopValid,
  input  logic              snoopKind,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic              pendCore,
  input  logic [LINE_W-1:0] pendLine,
  output mesi_t             mineSt,
  output mesi_t             otherSt,
  output logic              extHit,
  output logic              rspValid,
  output logic              rspCore,
  output mesi_t             rspState,
  output logic              rspExt
);
  localparam int LINES = 1 << LINE_W;

  logic [LINES-1:0][1:0][1:0] stVec;
  logic [LINES-1:0]           extVec;
  mesi_t                      fillSt;

  assign mineSt  = mesi_t'(stVec[reqLine][reqCore]);
  assign otherSt = mesi_t'(stVec[reqLine][~reqCore]);
  assign extHit  = extVec[reqLine];
  assign fillSt  = (otherSt != ST_I || extHit) ? ST_S : ST_E;

  function automatic logic [1:0] snoopNext(input logic [1:0] cur, input logic kind);
    if (kind == SNP_INV) return ST_I;
    if (cur == ST_M || cur == ST_E) return ST_S;
    return cur;
  endfunction

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [1:0][1:0] s;
    logic            e;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s <= '0;
        e <= 1'b0;
      end else if (stb.finishExt && pendLine == LINE_W'(g)) begin
        s[pendCore]  <= ST_M;
        s[~pendCore] <= ST_I;
        e            <= 1'b0;
      end else if (snoopValid && snoopLine == LINE_W'(g)) begin
        s[0] <= snoopNext(s[0], snoopKind);
        s[1] <= snoopNext(s[1], snoopKind);
        e    <= 1'b1;
      end else if (reqLine == LINE_W'(g)) begin
        if (stb.localOwn) begin
          s[reqCore]  <= ST_M;
          s[~reqCore] <= ST_I;
        end else if (stb.fillRead) begin
          s[reqCore] <= fillSt;
          if (otherSt == ST_M || otherSt == ST_E) s[~reqCore] <= ST_S;
        end
      end
    end

    assign stVec[g]  = s;
    assign extVec[g] = e;

    // R9: an owner in M or E excludes any copy in the neighbour
    a_r9_single_owner: assert property (@(posedge clk) disable iff (!rstN)
      !(((s[0] == ST_M || s[0] == ST_E) && s[1] != ST_I) ||
        ((s[1] == ST_M || s[1] == ST_E) && s[0] != ST_I)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCore  <= 1'b0;
      rspState <= ST_I;
      rspExt   <= 1'b0;
    end else begin
      rspValid <= 1'b0;
      if (stb.finishExt) begin
        rspValid <= 1'b1;
        rspCore  <= pendCore;
        rspState <= ST_M;
        rspExt   <= 1'b1;
      end else if (stb.localOwn || stb.fillRead || stb.hitRead) begin
        rspValid <= 1'b1;
        rspCore  <= reqCore;
        rspExt   <= 1'b0;
        if (stb.localOwn)      rspState <= ST_M;
        else if (stb.fillRead) rspState <= fillSt;
        else                   rspState <= mineSt;
      end
    end
  end

  a_r3_local_own_rsp: assert property (@(posedge clk) disable iff (!rstN)
    stb.localOwn |=> rspValid && rspState == ST_M && !rspExt);

  a_r4_ext_rsp_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspExt |-> $past(stb.finishExt));

  a_r6_fill_state: assert property (@(posedge clk) disable iff (!rstN)
    stb.fillRead |=> rspValid && (rspState == ST_S || rspState == ST_E));
endmodule

// File: rtl/own_control.sv
module own_control
  import own_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqCore,
  input  logic              reqOp,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              snoopValid,
  input  logic [LINE_W-1:0] snoopLine,
  input  logic              extGrant,
  input  mesi_t             mineSt,
  input  logic              extHit,
  output logic              reqReady,
  output strobe_t           stb,
  output logic              pendCore,
  output logic [LINE_W-1:0] pendLine,
  output logic              extReqValid,
  output logic [LINE_W-1:0] extReqLine
);
  typedef enum logic {CS_IDLE, CS_WAIT} cstate_t;
  cstate_t cState;

  logic waiting, needOwn, needExt, sameLine, snoopClash, grantNow, accept;

  assign waiting    = (cState == CS_WAIT);
  assign needOwn    = (reqOp == OP_WRITE) && !(mineSt == ST_M || mineSt == ST_E);
  assign needExt    = needOwn && extHit;
  assign sameLine   = waiting && (pendLine == reqLine);
  assign snoopClash = snoopValid && (snoopLine == reqLine);
  assign grantNow   = waiting && extGrant;

  assign reqReady = !snoopClash && !sameLine && !grantNow && !(needExt && waiting);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stb           = '0;
    stb.localOwn  = accept && (reqOp == OP_WRITE) && !needExt;
    stb.launchExt = accept && needExt;
    stb.fillRead  = accept && (reqOp == OP_READ) && (mineSt == ST_I);
    stb.hitRead   = accept && (reqOp == OP_READ) && (mineSt != ST_I);
    stb.finishExt = grantNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cState   <= CS_IDLE;
      pendLine <= '0;
      pendCore <= 1'b0;
    end else begin
      case (cState)
        CS_IDLE: if (stb.launchExt) begin
          cState   <= CS_WAIT;
          pendLine <= reqLine;
          pendCore <= reqCore;
        end
        CS_WAIT: if (extGrant) cState <= CS_IDLE;
        default: cState <= CS_IDLE;
      endcase
    end
  end

  assign extReqValid = waiting;
  assign extReqLine  = pendLine;

  a_r4_ext_hold: assert property (@(posedge clk) disable iff (!rstN)
    extReqValid && !extGrant |=> extReqValid && $stable(extReqLine));

  a_r8_no_accept_pending_line: assert property (@(posedge clk) disable iff (!rstN)
    extReqValid |-> !(reqValid && reqReady && reqLine == extReqLine));

  a_r8_one_ext_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    extReqValid && !extGrant |-> !stb.launchExt);
endmodule

// File: rtl/ownership_ctrl.sv
module ownership_ctrl
  import own_pkg::*;
#(
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqCore,
  input  logic              reqOp,
  input  logic [LINE_W-1:0] reqLine,
  output logic              rspValid,
  output logic              rspCore,
  output logic [1:0]        rspState,
  output logic              rspExt,
  input  logic              snoopValid,
  input  logic              snoopKind,
  input  logic [LINE_W-1:0] snoopLine,
  output logic              extReqValid,
  output logic [LINE_W-1:0] extReqLine,
  input  logic              extGrant
);
  strobe_t           stb;
  mesi_t             mineSt, otherSt, rspSt;
  logic              extHit, pendCore;
  logic [LINE_W-1:0] pendLine;

  own_control #(.LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqCore(reqCore), .reqOp(reqOp), .reqLine(reqLine),
    .snoopValid(snoopValid), .snoopLine(snoopLine), .extGrant(extGrant),
    .mineSt(mineSt), .extHit(extHit),
    .reqReady(reqReady), .stb(stb), .pendCore(pendCore), .pendLine(pendLine),
    .extReqValid(extReqValid), .extReqLine(extReqLine)
  );

  own_datapath #(.LINE_W(LINE_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqCore(reqCore), .reqLine(reqLine),
    .snoopValid(snoopValid), .snoopKind(snoopKind), .snoopLine(snoopLine),
    .pendCore(pendCore), .pendLine(pendLine),
    .mineSt(mineSt), .otherSt(otherSt), .extHit(extHit),
    .rspValid(rspValid), .rspCore(rspCore), .rspState(rspSt), .rspExt(rspExt)
  );

  assign rspState = rspSt;
endmodule

// File: tb/ownership_ctrl_bench.sv
module ownership_ctrl_bench;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       reqValid = 0, reqCore = 0, reqOp = 0;
  logic [2:0] reqLine = '0;
  logic       snoopValid = 0, snoopKind = 0;
  logic [2:0] snoopLine = '0;
  logic       extGrant = 0;
  logic       reqReady, rspValid, rspCore, rspExt, extReqValid;
  logic [1:0] rspState;
  logic [2:0] extReqLine;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  ownership_ctrl #(.LINE_W(3)) u_ownership_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCore(reqCore), .reqOp(reqOp), .reqLine(reqLine),
    .rspValid(rspValid), .rspCore(rspCore), .rspState(rspState), .rspExt(rspExt),
    .snoopValid(snoopValid), .snoopKind(snoopKind), .snoopLine(snoopLine),
    .extReqValid(extReqValid), .extReqLine(extReqLine), .extGrant(extGrant)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // issue one request, grant any external request, return the response
  task automatic issue(input logic c, input logic op, input logic [2:0] ln,
                       output logic [1:0] st, output logic ex, output logic saw);
    logic got;
    @(negedge clk);
    reqValid = 1; reqCore = c; reqOp = op; reqLine = ln;
    for (int n = 0; n < 50 && !reqReady; n++) @(negedge clk);
    @(negedge clk);
    reqValid = 0;
    got = 0; saw = 0; st = '0; ex = 0;
    for (int k = 0; k < 50 && !got; k++) begin
      if (rspValid) begin
        got = 1; st = rspState; ex = rspExt;
      end else begin
        if (extReqValid) begin saw = 1; extGrant = 1; end
        @(negedge clk);
        extGrant = 0;
      end
    end
    chk("response arrives", int'(got), 1);
  endtask

  task automatic snoop(input logic kind, input logic [2:0] ln);
    @(negedge clk);
    snoopValid = 1; snoopKind = kind; snoopLine = ln;
    @(negedge clk);
    snoopValid = 0;
  endtask

  // {core, op, line, expected state}; I=0 S=1 E=2 M=3
  localparam int NV = 14;
  localparam logic [6:0] vecTab [NV] = '{
    {1'b0, 1'b0, 3'd1, 2'd2},  // R6 miss, nobody holds: E
    {1'b0, 1'b0, 3'd1, 2'd2},  // R5 hit keeps E
    {1'b0, 1'b1, 3'd1, 2'd3},  // R2 silent E->M
    {1'b1, 1'b0, 3'd1, 2'd1},  // R6 other M -> S
    {1'b0, 1'b0, 3'd1, 2'd1},  // R5 demoted owner reads S
    {1'b1, 1'b1, 3'd1, 2'd3},  // R3 S->M locally
    {1'b0, 1'b0, 3'd1, 2'd1},  // R6 other M -> S
    {1'b1, 1'b0, 3'd4, 2'd2},  // R6 E
    {1'b0, 1'b0, 3'd4, 2'd1},  // R6 other E -> S
    {1'b0, 1'b1, 3'd4, 2'd3},  // R3 S->M locally
    {1'b1, 1'b1, 3'd4, 2'd3},  // R3 I->M locally
    {1'b0, 1'b0, 3'd4, 2'd1},  // R6 other M -> S
    {1'b0, 1'b1, 3'd0, 2'd3},  // R3 I->M, nobody else
    {1'b1, 1'b0, 3'd0, 2'd1}   // R6 other M -> S
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] st;
    logic ex, saw;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rspValid", int'(rspValid), 0);
    chk("R1 extReqValid", int'(extReqValid), 0);
    chk("R1 reqReady", int'(reqReady), 1);
    issue(1'b0, 1'b0, 3'd7, st, ex, saw);
    chk("R1 untouched line reads E", int'(st), 2);

    for (int i = 0; i < NV; i++) begin
      issue(vecTab[i][6], vecTab[i][5], vecTab[i][4:2], st, ex, saw);
      chk($sformatf("R2/R3/R5/R6 vector %0d state", i), int'(st), int'(vecTab[i][1:0]));
      chk($sformatf("R3 vector %0d no external", i), int'(saw | ex), 0);
    end

    // R7 external read snoop demotes E to S
    issue(1'b0, 1'b0, 3'd5, st, ex, saw);
    chk("R6 line5 E", int'(st), 2);
    snoop(1'b0, 3'd5);
    issue(1'b0, 1'b0, 3'd5, st, ex, saw);
    chk("R7 read snoop demotes to S", int'(st), 1);
    issue(1'b1, 1'b0, 3'd5, st, ex, saw);
    chk("R6 outside sharer gives S", int'(st), 1);
    issue(1'b1, 1'b1, 3'd5, st, ex, saw);
    chk("R4 external write state", int'(st), 3);
    chk("R4 external write rspExt", int'(ex), 1);
    chk("R4 request seen on bus", int'(saw), 1);
    snoop(1'b1, 3'd5);
    issue(1'b1, 1'b0, 3'd5, st, ex, saw);
    chk("R7 invalidate snoop then miss gives S", int'(st), 1);

    // R8 snoop to same line stalls the request
    @(negedge clk);
    snoopValid = 1; snoopKind = 0; snoopLine = 3'd2;
    reqOp = 0; reqLine = 3'd2; reqCore = 0;
    #1 chk("R8 snoop clash stalls", int'(reqReady), 0);
    @(negedge clk);
    snoopValid = 0;
    issue(1'b0, 1'b0, 3'd2, st, ex, saw);
    chk("R6 after snoop read S", int'(st), 1);

    // R4 / R8 hold the grant back
    @(negedge clk);
    reqValid = 1; reqCore = 0; reqOp = 1; reqLine = 3'd2;
    #1 chk("R8 first ownership accepted", int'(reqReady), 1);
    @(negedge clk);
    reqValid = 0;
    chk("R4 extReqValid raised", int'(extReqValid), 1);
    chk("R4 extReqLine", int'(extReqLine), 2);
    chk("R4 no response before grant", int'(rspValid), 0);
    reqCore = 1; reqOp = 0; reqLine = 3'd2;
    #1 chk("R8 same line stalls", int'(reqReady), 0);
    reqLine = 3'd3;
    #1 chk("R8 other line proceeds", int'(reqReady), 1);
    reqCore = 1; reqOp = 1; reqLine = 3'd5;
    #1 chk("R8 second external need stalls", int'(reqReady), 0);
    repeat (3) @(negedge clk);
    chk("R4 request held", int'(extReqValid), 1);
    chk("R4 line held", int'(extReqLine), 2);
    extGrant = 1;
    @(negedge clk);
    extGrant = 0;
    chk("R4 response after grant", int'(rspValid), 1);
    chk("R4 response core", int'(rspCore), 0);
    chk("R4 response state M", int'(rspState), 3);
    chk("R4 response rspExt", int'(rspExt), 1);
    chk("R4 request dropped", int'(extReqValid), 0);
    issue(1'b1, 1'b0, 3'd2, st, ex, saw);
    chk("R6 other M gives S", int'(st), 1);
    issue(1'b0, 1'b1, 3'd2, st, ex, saw);
    chk("R4 outside bit cleared: local M", int'(st), 3);
    chk("R4 outside bit cleared: no bus", int'(saw | ex), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule